// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit takes two 32-bit operands and a carry bit, and it runs one of four integer operations on them. The result is captured in a register one clock after the input strobe.

The two compare operations return the difference B minus A. When the operands' top bits differ, the top bit of that difference is replaced so that it gives the true ordering. The signed form puts B's top bit there. The unsigned form puts A's top bit there. The difference itself is left as it is, so downstream logic can use it as an ordering flag or as a value.

The byte-match operation scans the four byte lanes from the most significant lane down. It reports the 1-based position of the first lane in which both operands hold the same byte.

The carry operation reports whether A + B + carry-in overflows the word.

Each accepted request produces exactly one valid output one cycle later. With no request, the outputs hold their last values.

Top module: `cmpx_unit`

## Requirements
- R1: With op_sel = 0 (signed compare) and bit 31 of A and B different, res[30:0] equals bits 30:0 of (B - A) mod 2^32, and res[31] equals B[31].
- R2: With op_sel = 1 (unsigned compare) and bit 31 of A and B different, res[30:0] equals bits 30:0 of (B - A) mod 2^32, and res[31] equals A[31].
- R3: With op_sel = 0 or 1 and bit 31 of A and B equal, res equals (B - A) mod 2^32 unchanged.
- R4: With op_sel = 2 (byte match), res is the 1-based index of the first equal lane, scanning in the order bits 31:24 (index 1), 23:16 (index 2), 15:8 (index 3), 7:0 (index 4).
- R5: With op_sel = 2 and no byte lane equal, res is 0.
- R6: With op_sel = 3 (carry), cout is 1 exactly when A + B + cin is 2^32 or more, and res is 0.
- R7: For op_sel values 0, 1 and 2, cout is 0.
- R8: out_valid equals the in_valid value sampled at the previous rising clock edge.
- R9: When in_valid is low at a rising edge, res and cout keep their previous values.
- R10: A synchronous active-high rst clears out_valid, res and cout to 0 at the next rising edge, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands are taken on this edge |
| op_sel | input | 2 | 0 signed compare, 1 unsigned compare, 2 byte match, 3 carry |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| cin | input | 1 | Carry-in for the carry operation |
| res | output | 32 | Registered result |
| cout | output | 1 | Registered carry-out |
| out_valid | output | 1 | High one cycle after an accepted request |

## Verification
The assertions assume that rst is high on the first clock edge, so that no output is judged before the registers have a defined value. They also assume that op_sel carries one of its four codes whenever in_valid is high.

The bench keeps rst asserted at time zero and pulses it once again in mid-run. It drives only the four legal codes. Between requests it also leaves in_valid low for some cycles, with the other inputs toggling, so that the hold behaviour gets exercised.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

    typedef enum logic [1:0] {
        OP_SCMP   = 2'd0,
        OP_UCMP   = 2'd1,
        OP_BMATCH = 2'd2,
        OP_CARRY  = 2'd3
    } cmpx_op_e;

endpackage

// File: rtl/cmpx_diff.sv
module cmpx_diff #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_signed,
    output logic [WIDTH-1:0] diff
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] raw;

    always_comb begin
        raw  = b + ~a + {{(WIDTH-1){1'b0}}, 1'b1};
        diff = raw;
        if (a[MSB] != b[MSB]) begin
            diff[MSB] = is_signed ? b[MSB] : a[MSB];
        end
    end

endmodule

// File: rtl/cmpx_lane.sv
module cmpx_lane #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned NLANES = WIDTH / LANE_W;

    logic [NLANES-1:0] hit;

    genvar k;
    generate
        for (k = 0; k < NLANES; k++) begin : g_lane
            assign hit[k] = (a[k*LANE_W +: LANE_W] == b[k*LANE_W +: LANE_W]);
        end
    endgenerate

    // Ascending scan; the most significant matching lane is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (hit[i]) begin
                idx = IDX_W'(NLANES - i);
            end
        end
    end

endmodule

// File: rtl/cmpx_carry.sv
module cmpx_carry #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic             cout
);
    // a + b overflows when a exceeds the headroom ~b; equality leaves room only without cin.
    logic [WIDTH-1:0] room;

    always_comb begin
        room = ~b;
        cout = (a > room) || ((a == room) && cin);
    end

endmodule

// File: rtl/cmpx_unit.sv
module cmpx_unit
    import cmpx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              out_valid
);
    localparam int unsigned NLANES = DATA_W / LANE_W;
    localparam int unsigned IDX_W  = $clog2(NLANES + 1);

    typedef struct packed {
        logic              vld;
        cmpx_op_e          op;
        logic [DATA_W-1:0] res;
        logic              cout;
    } cmpx_state_t;

    cmpx_state_t st_d, st_q;

    cmpx_op_e          op_in;
    logic [DATA_W-1:0] diff_w;
    logic [IDX_W-1:0]  lane_w;
    logic              carry_w;

    assign op_in = cmpx_op_e'(op_sel);

    cmpx_diff #(.WIDTH(DATA_W)) u_diff (
        .a         (opa),
        .b         (opb),
        .is_signed (op_in == OP_SCMP),
        .diff      (diff_w)
    );

    cmpx_lane #(.WIDTH(DATA_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_lane (
        .a   (opa),
        .b   (opb),
        .idx (lane_w)
    );

    cmpx_carry #(.WIDTH(DATA_W)) u_carry (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .cout (carry_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.op   = op_in;
            st_d.cout = 1'b0;
            unique case (op_in)
                OP_SCMP, OP_UCMP: st_d.res = diff_w;
                OP_BMATCH:        st_d.res = DATA_W'(lane_w);
                OP_CARRY: begin
                    st_d.res  = '0;
                    st_d.cout = carry_w;
                end
                default:          st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res       = st_q.res;
    assign cout      = st_q.cout;
    assign out_valid = st_q.vld;

    AST_VALID_ONE_LAG: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                            // R8
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                          // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res) && $stable(cout)));                     // R9
    AST_COUT_CARRY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != 2'd3) |=> !cout);                            // R7
    AST_MATCH_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd2) |=> (res <= DATA_W'(NLANES)));          // R4
    AST_CARRY_RES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd3) |=> (res == '0));                      // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && !cout && res == '0));                        // R10

endmodule

// File: tb/cmpx_unit_test.sv
module cmpx_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cin = 1'b0;
    logic [31:0] res;
    logic        cout;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_res  = '0;
    logic        m_cout = 1'b0;
    logic        m_vld  = 1'b0;

    always #2 clk = ~clk;

    cmpx_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .cin(cin),
        .res(res), .cout(cout), .out_valid(out_valid)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: arithmetic on wide integers.
    function automatic logic [31:0] ref_cmp(input logic [31:0] a, input logic [31:0] b, input bit sgn);
        longint d;
        logic [31:0] r;
        d = (longint'(b) - longint'(a)) & 64'hFFFF_FFFF;
        r = d[31:0];
        if ((a >> 31) != (b >> 31)) r[31] = sgn ? b[31] : a[31];
        return r;
    endfunction

    function automatic logic [31:0] ref_match(input logic [31:0] a, input logic [31:0] b);
        for (int i = 0; i < 4; i++) begin
            if (((a >> (24 - 8*i)) & 32'hFF) == ((b >> (24 - 8*i)) & 32'hFF)) return 32'(i + 1);
        end
        return 32'd0;
    endfunction

    function automatic logic ref_carry(input logic [31:0] a, input logic [31:0] b, input logic c);
        longint s;
        s = longint'(a) + longint'(b) + longint'(c);
        return s > 64'hFFFF_FFFF;
    endfunction

    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic c);
        string rtag;
        @(negedge clk);
        in_valid = v; op_sel = op; opa = a; opb = b; cin = c;
        @(posedge clk);
        #1;
        rtag = "R9";
        m_vld = v;
        if (v) begin
            m_cout = 1'b0;
            case (op)
                2'd0: begin m_res = ref_cmp(a, b, 1); rtag = (a[31] != b[31]) ? "R1" : "R3"; end
                2'd1: begin m_res = ref_cmp(a, b, 0); rtag = (a[31] != b[31]) ? "R2" : "R3"; end
                2'd2: begin m_res = ref_match(a, b); rtag = (m_res == 0) ? "R5" : "R4"; end
                default: begin m_res = '0; m_cout = ref_carry(a, b, c); rtag = "R6"; end
            endcase
        end
        check(rtag, res, m_res);
        check((v && op == 2'd3) ? "R6" : (v ? "R7" : "R9"), cout, m_cout);
        check("R8", out_valid, m_vld);
    endtask

    task automatic do_reset(input bit v);
        @(negedge clk);
        rst = 1'b1; in_valid = v; op_sel = 2'd3; opa = '1; opb = '1; cin = 1'b1;
        @(posedge clk);
        #1;
        m_res = '0; m_cout = 1'b0; m_vld = 1'b0;
        check("R10", res, 0);
        check("R10", cout, 0);
        check("R10", out_valid, 0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R1 / R2: top bits differ
        step(1, 2'd0, 32'h8000_0000, 32'h0000_0001, 0);
        step(1, 2'd0, 32'h0000_0005, 32'hFFFF_FFF0, 0);
        step(1, 2'd1, 32'h8000_0000, 32'h0000_0001, 0);
        step(1, 2'd1, 32'h0000_0005, 32'hFFFF_FFF0, 0);
        // R3: top bits equal
        step(1, 2'd0, 32'h0000_0010, 32'h0000_0003, 0);
        step(1, 2'd1, 32'hFFFF_0000, 32'hFFFF_0000, 0);
        step(1, 2'd0, 32'h7FFF_FFFF, 32'h0000_0000, 0);
        // R4 / R5: lane priority
        step(1, 2'd2, 32'h1122_3344, 32'h1199_3344, 0);
        step(1, 2'd2, 32'h1122_3344, 32'h0022_3300, 0);
        step(1, 2'd2, 32'h1122_3344, 32'h0000_3300, 0);
        step(1, 2'd2, 32'h1122_3344, 32'h0000_0044, 0);
        step(1, 2'd2, 32'h1122_3344, 32'h0011_2233, 0);
        // R6: carry boundaries
        step(1, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1);
        step(1, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 0);
        step(1, 2'd3, 32'h0000_0001, 32'hFFFF_FFFF, 0);
        step(1, 2'd3, 32'h8000_0000, 32'h7FFF_FFFF, 1);
        step(1, 2'd3, 32'h8000_0000, 32'h7FFF_FFFE, 1);
        // R9: idle with toggling inputs
        step(0, 2'd0, 32'h1234_5678, 32'h8765_4321, 1);
        step(0, 2'd2, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0);
        step(1, 2'd1, 32'h0000_0001, 32'h8000_0000, 0);
        step(0, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 5 == 0) rb[15:8] = ra[15:8];
            step(($urandom % 4) != 0, 2'($urandom), ra, rb, 1'($urandom));
        end
        do_reset(1'b1);
        step(1, 2'd0, 32'h0000_0001, 32'h0000_0002, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule